// File: doc/BRIEF.md
# FM Synthesizer Timer and Interrupt Status Unit

This block provides the host-visible timer and interrupt-status logic of a legacy FM sound generator. The host reaches it through two index/data port pairs, a left bank and a right bank. A write to the index port of a bank selects a register in that bank, and a later write to the data port of the same bank stores a byte there. Every data write goes into a per-bank register file that the host can read back. Only three left-bank registers have any further effect: the two timer presets and the timer control register.

The unit holds two 8-bit up-counting timers. They advance on strobes from a shared clock-enable divider. The fast timer ticks once per 80 µs and the slow timer four times slower. A timer that overflows past 0xFF reloads its preset and keeps counting. If the timer is unmasked, the overflow also raises a sticky flag. The status byte, read from the left index port, reports the two flags, a combined interrupt bit and a fixed identity code. The interrupt output follows the combined bit. A control write with its top bit set clears both flags and leaves the timer configuration unchanged.

Top module: `fm_timer_unit`

## Requirements
- R1: An index-port write (`hb_a0`=0) latches the index for the selected bank only. A data-port write (`hb_a0`=1) stores the byte at that bank's latched index in a 2×256-byte register file. A data-port read returns that stored byte on `hb_rdata` in the cycle after `hb_rd`.
- R2: Timer 1 advances once every CLK_HZ/12500 clock cycles (80 µs). Timer 2 advances once every four timer-1 periods (320 µs).
- R3: Writing 256−N to a timer's preset (left index 0x02 for timer 1, 0x03 for timer 2) makes a started timer expire after N ticks. A preset of 0x00 gives 256 ticks.
- R4: On expiry the timer reloads its preset and keeps running, so it expires again every N ticks.
- R5: A timer whose mask bit is set never raises its flag. Clearing the mask while the timer runs lets its next expiry raise the flag.
- R6: A control write (left index 0x04) with bit 7 set clears both flags and does not change the masks or starts.
- R7: Status bit 7 and `irq_o` are the OR of the flags whose timers are unmasked. A flag that is already set stays visible in its own bit after its timer is masked.
- R8: A read of the left index port returns the status byte: bit 7 interrupt, bit 6 timer-1 flag, bit 5 timer-2 flag, bits 4:0 the identity code (default 0x06). A read of the right index port returns 0x00.
- R9: A control write with bit 7 clear sets mask1 from bit 6, mask2 from bit 5, start2 from bit 1 and start1 from bit 0. A start going 0→1 loads the preset. A cleared start halts the timer.
- R10: Right-bank writes, and left-bank writes to any index other than 0x02–0x04, only update the register file.
- R11: After reset the status reads 0x06, `irq_o` is 0, both timers are stopped and unmasked, and both index latches are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_bank | input | 1 | Bank select: 0 left, 1 right |
| hb_a0 | input | 1 | Port select: 0 index/status, 1 data |
| hb_wdata | input | 8 | Host write byte |
| hb_rdata | output | 8 | Read data, valid the cycle after `hb_rd` |
| irq_o | output | 1 | Interrupt request, mirrors status bit 7 |

## Verification
The expiry time is swept over several preset values for each timer, from one tick up to the full 256 ticks. Each measured latency must fall in the window the tick period predicts, which separates the two periods and catches off-by-one preset handling. A fixed detection-style sequence exercises the status byte: mask and clear, a single-tick preset, then both timers together. The expected values 0x06, 0xC6, 0xE6, 0xA6 and 0x26 separate flag setting, masking and the combined bit. The stimulus also includes writes to the right bank, writes to unrelated indexes and interleaved index writes to the two banks, all checked through register-file readback. These show that bank routing and the index latches are kept apart.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam logic [7:0] IDX_PRESET1 = 8'h02;
  localparam logic [7:0] IDX_PRESET2 = 8'h03;
  localparam logic [7:0] IDX_CONTROL = 8'h04;

  // Timer configuration held by the control register
  typedef struct packed {
    logic mask1;
    logic mask2;
    logic start2;
    logic start1;
  } tctl_t;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_DATA   = 2'd2
  } rdsel_e;
endpackage

// File: rtl/fmt_tick_gen.sv
module fmt_tick_gen #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned BASE_HZ = 12_500,
  parameter int unsigned RATIO   = 4
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] tick_o
);
  localparam int unsigned DIV_RAW = CLK_HZ / BASE_HZ;
  localparam int unsigned DIV     = (DIV_RAW == 0) ? 1 : DIV_RAW;
  localparam int unsigned CW      = $clog2(DIV + 1);
  localparam int unsigned RW      = $clog2(RATIO + 1);

  logic [CW-1:0] cnt;
  logic [RW-1:0] sub;
  logic          base_last;
  logic          sub_last;

  assign base_last = (cnt == CW'(DIV - 1));
  assign sub_last  = (sub == RW'(RATIO - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sub    <= '0;
      tick_o <= '0;
    end else begin
      tick_o <= '0;
      if (base_last) begin
        cnt       <= '0;
        tick_o[0] <= 1'b1;
        if (sub_last) begin
          sub       <= '0;
          tick_o[1] <= 1'b1;
        end else begin
          sub <= sub + RW'(1);
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2: the slow strobe always lands on a fast strobe
  assert_tick_align_R2: assert property (@(posedge clk) disable iff (rst)
    tick_o[1] |-> tick_o[0]);
endmodule

// File: rtl/fmt_timer.sv
module fmt_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] preset,
  output logic         expire_o
);
  logic [W-1:0] cnt;
  logic         start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      start_q  <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      start_q  <= start;
      expire_o <= 1'b0;
      if (start && !start_q) begin
        cnt <= preset;
      end else if (start && tick) begin
        if (cnt == '1) begin
          cnt      <= preset;
          expire_o <= 1'b1;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end

  // R3: a running timer steps by one per tick below the top value
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (start && start_q && tick && cnt != '1) |=> (cnt == $past(cnt) + W'(1)));

  // R4: overflow reloads the preset and reports expiry
  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (start && start_q && tick && cnt == '1) |=> (expire_o && cnt == $past(preset)));
endmodule

// File: rtl/fmt_regfile.sv
module fmt_regfile #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fm_timer_unit.sv
module fm_timer_unit #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned TW     = 8,
  parameter logic [4:0]  ID_SIG = 5'h06
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hb_wr,
  input  logic       hb_rd,
  input  logic       hb_bank,
  input  logic       hb_a0,
  input  logic [7:0] hb_wdata,
  output logic [7:0] hb_rdata,
  output logic       irq_o
);
  import fmt_pkg::*;

  localparam int unsigned NT = 2;
  localparam int unsigned AW = 9;

  logic [7:0]    idx_q [2];
  logic [TW-1:0] preset_q [NT];
  tctl_t         ctl;
  logic [NT-1:0] tick;
  logic [NT-1:0] expire;
  logic [NT-1:0] flags;
  logic [NT-1:0] mask;
  logic [NT-1:0] start;
  logic [7:0]    status_q;
  logic [7:0]    rf_q;
  rdsel_e        rdsel_q;

  logic          data_wr;
  logic          left_wr;
  logic [7:0]    wr_idx;
  logic          ctl_wr;
  logic          irq_clr;
  logic          irq_n;

  assign data_wr = hb_wr && hb_a0;
  assign wr_idx  = idx_q[hb_bank];
  assign left_wr = data_wr && !hb_bank;
  assign ctl_wr  = left_wr && (wr_idx == IDX_CONTROL);
  assign irq_clr = ctl_wr && hb_wdata[7];
  assign mask    = {ctl.mask2, ctl.mask1};
  assign start   = {ctl.start2, ctl.start1};
  assign irq_n   = |(flags & ~mask);

  fmt_tick_gen #(.CLK_HZ(CLK_HZ), .BASE_HZ(12_500), .RATIO(4)) tick_i (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    fmt_timer #(.W(TW)) tmr_i (
      .clk(clk), .rst(rst), .tick(tick[t]), .start(start[t]),
      .preset(preset_q[t]), .expire_o(expire[t])
    );

    // R5: a flag only rises from an unmasked timer
    assert_mask_gate_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[t]) |-> !$past(mask[t]));
  end

  fmt_regfile #(.AW(AW), .DW(8)) rf_i (
    .clk(clk), .we(data_wr),
    .waddr({hb_bank, wr_idx}), .wdata(hb_wdata),
    .raddr({hb_bank, idx_q[hb_bank]}), .rdata(rf_q)
  );

  // Index latches
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q[0] <= '0;
      idx_q[1] <= '0;
    end else if (hb_wr && !hb_a0) begin
      idx_q[hb_bank] <= hb_wdata;
    end
  end

  // Timer presets and control
  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q[0] <= '0;
      preset_q[1] <= '0;
      ctl         <= '0;
    end else if (left_wr) begin
      if (wr_idx == IDX_PRESET1) preset_q[0] <= hb_wdata[TW-1:0];
      if (wr_idx == IDX_PRESET2) preset_q[1] <= hb_wdata[TW-1:0];
      if (ctl_wr && !hb_wdata[7])
        ctl <= '{mask1: hb_wdata[6], mask2: hb_wdata[5],
                 start2: hb_wdata[1], start1: hb_wdata[0]};
    end
  end

  // Sticky flags, status and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      status_q <= {3'b000, ID_SIG};
      irq_o    <= 1'b0;
    end else begin
      if (irq_clr) flags <= '0;
      else         flags <= flags | (expire & ~mask);
      status_q <= {irq_n, flags[0], flags[1], ID_SIG};
      irq_o    <= irq_n;
    end
  end

  // Read select
  always_ff @(posedge clk) begin
    if (rst) begin
      rdsel_q <= RD_ZERO;
    end else if (hb_rd) begin
      if (hb_a0)        rdsel_q <= RD_DATA;
      else if (!hb_bank) rdsel_q <= RD_STATUS;
      else              rdsel_q <= RD_ZERO;
    end
  end

  always_comb begin
    unique case (rdsel_q)
      RD_STATUS: hb_rdata = status_q;
      RD_DATA:   hb_rdata = rf_q;
      default:   hb_rdata = 8'h00;
    endcase
  end

  // R6: interrupt reset empties the flags and leaves the control alone
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> (flags == '0));
  assert_ctl_keep_R6: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> $stable(ctl));

  // R7: a raised interrupt always has a flag behind it
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (status_q[6] || status_q[5]));

  // R10: right-bank data writes leave the timer registers alone
  assert_right_inert_R10: assert property (@(posedge clk) disable iff (rst)
    (data_wr && hb_bank) |=> ($stable(ctl) && $stable(preset_q[0]) && $stable(preset_q[1])));
endmodule

// File: tb/fm_timer_unit_tb.sv
module fm_timer_unit_tb_top;
  localparam int unsigned CLK_HZ = 100_000;
  localparam int D1 = CLK_HZ / 12_500;
  localparam int D2 = 4 * D1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hb_wr = 1'b0;
  logic       hb_rd = 1'b0;
  logic       hb_bank = 1'b0;
  logic       hb_a0 = 1'b0;
  logic [7:0] hb_wdata = 8'h00;
  logic [7:0] hb_rdata;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fm_timer_unit #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_bank(hb_bank),
    .hb_a0(hb_a0), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic check_rng(input string req, input int got, input int lo, input int hi);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s got %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  task automatic bus_wr(input bit bank, input bit a0, input logic [7:0] d);
    @(negedge clk);
    hb_wr = 1'b1; hb_bank = bank; hb_a0 = a0; hb_wdata = d;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic reg_write(input bit bank, input logic [7:0] idx, input logic [7:0] d);
    bus_wr(bank, 1'b0, idx);
    bus_wr(bank, 1'b1, d);
  endtask

  task automatic bus_rd(input bit bank, input bit a0, output logic [7:0] d);
    @(negedge clk);
    hb_rd = 1'b1; hb_bank = bank; hb_a0 = a0;
    @(negedge clk);
    hb_rd = 1'b0;
    d = hb_rdata;
  endtask

  task automatic status(output logic [7:0] d);
    bus_rd(1'b0, 1'b0, d);
  endtask

  task automatic quiesce();
    reg_write(1'b0, 8'h04, 8'h60);
    reg_write(1'b0, 8'h04, 8'h80);
  endtask

  // Cycles from the start write until irq_o, compared to the tick window
  task automatic measure(input int tsel, input int n, input string req);
    int c;
    int d;
    d = (tsel == 1) ? D1 : D2;
    quiesce();
    reg_write(1'b0, (tsel == 1) ? 8'h02 : 8'h03, 8'(256 - n));
    reg_write(1'b0, 8'h04, (tsel == 1) ? 8'h21 : 8'h42);
    c = 0;
    while (!irq_o && c < n * d + 50) begin
      @(negedge clk);
      c++;
    end
    check_rng(req, c, (n - 1) * d + 1, n * d + 4);
    quiesce();
  endtask

  function automatic logic [7:0] pat(input bit bank, input logic [7:0] idx);
    return idx ^ (bank ? 8'hA5 : 8'h3C);
  endfunction

  initial begin
    logic [7:0] v;
    logic [7:0] idxs [8] = '{8'h00, 8'h01, 8'h08, 8'h20, 8'hB0, 8'hBD, 8'hFF, 8'h05};
    int c;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 / R8: reset state
    status(v);
    check("R11 reset status", v, 8'h06);
    check("R11 reset irq", irq_o, 0);
    bus_rd(1'b1, 1'b0, v);
    check("R8 right index port reads zero", v, 8'h00);

    // R1 / R10: register file fill and readback, banks interleaved
    for (int i = 0; i < 8; i++) begin
      reg_write(1'b0, idxs[i], pat(1'b0, idxs[i]));
      reg_write(1'b1, idxs[i], pat(1'b1, idxs[i]));
    end
    reg_write(1'b1, 8'h04, 8'h03);
    reg_write(1'b1, 8'h02, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      for (int b = 0; b < 2; b++) begin
        bus_wr(b[0], 1'b0, idxs[i]);
        bus_rd(b[0], 1'b1, v);
        check("R1 register file readback", v, pat(b[0], idxs[i]));
      end
    end
    // R1: index latches are per bank
    bus_wr(1'b0, 1'b0, 8'h20);
    bus_wr(1'b1, 1'b0, 8'hB0);
    bus_wr(1'b0, 1'b1, 8'h5A);
    bus_rd(1'b1, 1'b1, v);
    check("R1 right index kept", v, pat(1'b1, 8'hB0));
    bus_rd(1'b0, 1'b1, v);
    check("R1 left write to left index", v, 8'h5A);
    bus_wr(1'b1, 1'b0, 8'h04);
    bus_rd(1'b1, 1'b1, v);
    check("R1 right copy of index 04", v, 8'h03);
    // R10: right bank control/preset writes start nothing
    repeat (300) @(negedge clk);
    status(v);
    check("R10 right bank has no timer effect", v, 8'h06);

    // R8 / R3 / R7: detection sequence
    quiesce();
    status(v);
    check("R8 masked and cleared status", v, 8'h06);
    reg_write(1'b0, 8'h02, 8'hFF);
    reg_write(1'b0, 8'h04, 8'h21);
    repeat (3 * D1) @(negedge clk);
    status(v);
    check("R8 timer1 expired status", v, 8'hC6);
    check("R7 irq follows bit 7", irq_o, 1);

    // R6 / R4: clear keeps timer running, flag returns after N ticks
    quiesce();
    reg_write(1'b0, 8'h02, 8'hF0);
    reg_write(1'b0, 8'h04, 8'h21);
    c = 0;
    while (!irq_o && c < 400) begin @(negedge clk); c++; end
    reg_write(1'b0, 8'h04, 8'h80);
    status(v);
    check("R6 flags cleared", v, 8'h06);
    c = 0;
    while (!irq_o && c < 400) begin @(negedge clk); c++; end
    check_rng("R4 reload period after clear", c, 16 * D1 - 12, 16 * D1 + 4);
    check("R6 control kept after clear", irq_o, 1);

    // R5: masked timer 2 raises nothing, unmasked later it does
    quiesce();
    reg_write(1'b0, 8'h03, 8'hFE);
    reg_write(1'b0, 8'h04, 8'h62);
    repeat (4 * D2) @(negedge clk);
    status(v);
    check("R5 masked timer2 no flag", v, 8'h06);
    reg_write(1'b0, 8'h04, 8'h42);
    repeat (3 * D2) @(negedge clk);
    status(v);
    check("R5 unmasked timer2 flags", v, 8'hA6);
    // R7: masking after the flag drops bit 7 only
    reg_write(1'b0, 8'h04, 8'h60);
    status(v);
    check("R7 masked flag leaves bit 5", v, 8'h26);
    check("R7 irq drops", irq_o, 0);

    // R9: clearing start halts the timer
    quiesce();
    reg_write(1'b0, 8'h02, 8'hFF);
    reg_write(1'b0, 8'h04, 8'h01);
    reg_write(1'b0, 8'h04, 8'h00);
    reg_write(1'b0, 8'h04, 8'h80);
    repeat (4 * D1) @(negedge clk);
    status(v);
    check("R9 stopped timer stays idle", v, 8'h06);

    // Both timers together
    quiesce();
    reg_write(1'b0, 8'h02, 8'hFF);
    reg_write(1'b0, 8'h03, 8'hFF);
    reg_write(1'b0, 8'h04, 8'h03);
    repeat (3 * D2) @(negedge clk);
    status(v);
    check("R8 both flags", v, 8'hE6);

    // R2 / R3: expiry latency sweep
    measure(1, 1,   "R3 timer1 N=1");
    measure(1, 2,   "R3 timer1 N=2");
    measure(1, 3,   "R3 timer1 N=3");
    measure(1, 7,   "R3 timer1 N=7");
    measure(1, 16,  "R2 timer1 N=16");
    measure(1, 256, "R3 timer1 N=256");
    measure(2, 1,   "R2 timer2 N=1");
    measure(2, 2,   "R2 timer2 N=2");
    measure(2, 5,   "R2 timer2 N=5");
    measure(2, 16,  "R2 timer2 N=16");
    measure(2, 256, "R3 timer2 N=256");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule